// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This unit sits next to a single-precision arithmetic datapath. It does not compute the arithmetic result. It looks at the one or two 32-bit operands of each issued operation and decides whether the result has to be a NaN. When it does, the unit supplies that NaN word and an override strobe, so the datapath's own result is replaced. When a signalling NaN reaches an arithmetic operation, it also raises a sticky invalid-operation flag.

The NaN it produces depends on the operation class and on a default-NaN mode bit:

- **Arithmetic, default-NaN mode on:** the unit returns the canonical quiet NaN.
- **Arithmetic, default-NaN mode off:** the unit forwards the highest-priority NaN operand in quieted form.
- **Copy:** the NaN is passed through with only the requested sign edit.
- **Transfer:** the NaN is passed through bit-exact.

Both copy and transfer are silent and never raise the flag.

The selection logic is combinational, and the override strobe and result word are registered once. The invalid flag is a two-state machine: FLAG_CLEAR goes to FLAG_RAISED on a qualifying signalling operation. FLAG_RAISED goes back to FLAG_CLEAR on a clear pulse, but only if no qualifying operation arrives in the same cycle. In every other case each state holds.

Top module: `nan_result_sel`

## Requirements
- R1: An operand is a NaN only when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. Infinities and ordinary numbers never assert `ovr_valid`.
- R2: `ovr_valid` and `ovr_result` are registered and appear one clock after the accepted operation. A cycle with `in_valid` low yields `ovr_valid`=0 and `ovr_result`=0 on the following clock, as does an operation without a NaN operand.
- R3: For arithmetic (`op_class`=0) with `dflt_mode`=1, any NaN operand gives the result 0x7FC00000, whatever the operand fractions or `sign_act` are.
- R4: For arithmetic with `dflt_mode`=0, the result is one NaN operand with fraction bit 22 forced to 1. The choice follows this priority: signalling A, then signalling B, then quiet A, then quiet B. Fraction bit 22 is 0 for a signalling NaN and 1 for a quiet one. `sign_act` is ignored.
- R5: An accepted arithmetic operation with a signalling NaN among its operands sets `invalid_flag` on the next clock in both modes. Quiet NaNs alone do not set it.
- R6: For copy (`op_class`=1), a NaN operand A is output with only its sign edited. `sign_act` 0 keeps the sign, 1 clears it, 2 inverts it, and 3 keeps it. Signalling NaNs are not quieted, the flag is not set, and `dflt_mode` has no effect.
- R7: For transfer (`op_class`=2, and 3 behaves the same), a NaN operand A is output bit-exact. `sign_act` and `dflt_mode` are ignored, and the flag is not set.
- R8: `invalid_flag` stays set until a `flag_clr` pulse, which clears it on the next clock. If a set condition and `flag_clr` occur in the same cycle, the flag ends up set.
- R9: Operand B is examined only for arithmetic operations with `two_opnd`=1. Otherwise a NaN in B has no effect on any output.
- R10: While `rst_n` is low, `ovr_valid`, `ovr_result` and `invalid_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An operation is issued this cycle |
| op_class | input | 2 | 0 arithmetic, 1 copy, 2/3 transfer |
| dflt_mode | input | 1 | Default-NaN mode for arithmetic |
| sign_act | input | 2 | Copy sign edit: 0 keep, 1 clear, 2 invert, 3 keep |
| two_opnd | input | 1 | Arithmetic uses operand B too |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| flag_clr | input | 1 | Clear pulse for the invalid flag |
| ovr_valid | output | 1 | Result must be replaced by `ovr_result` |
| ovr_result | output | 32 | NaN result word, 0 when not overriding |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
All three results are due exactly one clock after the cycle in which an operation or clear pulse is presented: the override strobe, the result word and the flag's new state. The bench applies each stimulus just after a falling edge and samples 1 ns after the next rising edge, so each check sees only the register update caused by that stimulus. The flag checks clear and set in the same cycle, so each vector's expected flag depends on that vector alone. Directed steps then confirm that the flag holds across idle cycles and that an unissued operation is not seen.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'd0,
        OPC_COPY  = 2'd1,
        OPC_XFER  = 2'd2,
        OPC_RSVD  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SGN_KEEP = 2'd0,
        SGN_ABS  = 2'd1,
        SGN_NEG  = 2'd2,
        SGN_RSVD = 2'd3
    } sign_act_e;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
    } nan_kind_t;

endpackage

// File: rtl/nan_classify.sv
module nan_classify
    import nan_sel_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    output nan_kind_t             kind
);
    localparam int QBIT = FRAC_W - 1;

    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones     = &word[FRAC_W +: EXP_W];
        frac_nz      = |word[FRAC_W-1:0];
        kind.is_nan  = exp_ones && frac_nz;
        kind.is_snan = kind.is_nan && !word[QBIT];
        kind.is_qnan = kind.is_nan && word[QBIT];
    end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
    import nan_sel_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int N_OPND = 2
) (
    input  logic [EXP_W+FRAC_W:0] words [N_OPND],
    input  nan_kind_t             kinds [N_OPND],
    input  logic [N_OPND-1:0]     use_mask,
    output logic                  any_nan,
    output logic                  any_snan,
    output logic [EXP_W+FRAC_W:0] pick
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    logic [WORD_W-1:0] snan_word;
    logic [WORD_W-1:0] qnan_word;
    logic              snan_hit;
    logic              qnan_hit;

    // Walk from the last operand down so the lowest index wins.
    always_comb begin
        snan_word = '0;
        qnan_word = '0;
        snan_hit  = 1'b0;
        qnan_hit  = 1'b0;
        for (int i = N_OPND - 1; i >= 0; i--) begin
            if (use_mask[i] && kinds[i].is_snan) begin
                snan_word = words[i];
                snan_hit  = 1'b1;
            end
            if (use_mask[i] && kinds[i].is_qnan) begin
                qnan_word = words[i];
                qnan_hit  = 1'b1;
            end
        end
        any_snan = snan_hit;
        any_nan  = snan_hit || qnan_hit;
        pick     = snan_hit ? snan_word : qnan_word;
    end
endmodule

// File: rtl/invalid_sticky.sv
module invalid_sticky
    import nan_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (set_req) state_d = FLAG_RAISED;
            FLAG_RAISED: if (clr_req && !set_req) state_d = FLAG_CLEAR;
            default:     state_d = FLAG_CLEAR;
        endcase
    end

    assign flag = (state_q == FLAG_RAISED);
endmodule

// File: rtl/nan_result_sel.sv
module nan_result_sel
    import nan_sel_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [1:0]               op_class,
    input  logic                     dflt_mode,
    input  logic [1:0]               sign_act,
    input  logic                     two_opnd,
    input  logic [EXP_W+FRAC_W:0]    opnd_a,
    input  logic [EXP_W+FRAC_W:0]    opnd_b,
    input  logic                     flag_clr,
    output logic                     ovr_valid,
    output logic [EXP_W+FRAC_W:0]    ovr_result,
    output logic                     invalid_flag
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPND = 2;
    localparam int SIGN_B = WORD_W - 1;
    localparam int QBIT   = FRAC_W - 1;
    localparam logic [WORD_W-1:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] words [N_OPND];
    nan_kind_t         kinds [N_OPND];
    logic [N_OPND-1:0] use_mask;
    logic              any_nan;
    logic              any_snan;
    logic [WORD_W-1:0] pick;

    logic              hit_d;
    logic [WORD_W-1:0] res_d;
    logic              set_d;
    logic              ovr_valid_q;
    logic [WORD_W-1:0] ovr_result_q;

    op_class_e cls;
    sign_act_e sact;

    assign words[0] = opnd_a;
    assign words[1] = opnd_b;
    assign cls      = op_class_e'(op_class);
    assign sact     = sign_act_e'(sign_act);

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
            .word (words[g]),
            .kind (kinds[g])
        );
    end

    always_comb begin
        use_mask    = '0;
        use_mask[0] = 1'b1;
        use_mask[1] = two_opnd && (cls == OPC_ARITH);
    end

    nan_pick #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .N_OPND(N_OPND)) i_pick (
        .words    (words),
        .kinds    (kinds),
        .use_mask (use_mask),
        .any_nan  (any_nan),
        .any_snan (any_snan),
        .pick     (pick)
    );

    always_comb begin
        hit_d = 1'b0;
        res_d = '0;
        set_d = 1'b0;
        unique case (cls)
            OPC_ARITH: begin
                hit_d = any_nan;
                set_d = any_snan;
                if (dflt_mode) begin
                    res_d = DFLT_NAN;
                end else begin
                    res_d       = pick;
                    res_d[QBIT] = 1'b1;
                end
            end
            OPC_COPY: begin
                hit_d = kinds[0].is_nan;
                res_d = opnd_a;
                unique case (sact)
                    SGN_ABS:  res_d[SIGN_B] = 1'b0;
                    SGN_NEG:  res_d[SIGN_B] = ~opnd_a[SIGN_B];
                    SGN_KEEP,
                    SGN_RSVD: res_d[SIGN_B] = opnd_a[SIGN_B];
                    default:  res_d[SIGN_B] = opnd_a[SIGN_B];
                endcase
            end
            OPC_XFER,
            OPC_RSVD: begin
                hit_d = kinds[0].is_nan;
                res_d = opnd_a;
            end
            default: begin
                hit_d = 1'b0;
                res_d = '0;
            end
        endcase
        hit_d = hit_d && in_valid;
        set_d = set_d && in_valid;
        if (!hit_d) res_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_valid_q  <= 1'b0;
            ovr_result_q <= '0;
        end else begin
            ovr_valid_q  <= hit_d;
            ovr_result_q <= res_d;
        end
    end

    invalid_sticky i_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_d),
        .clr_req (flag_clr),
        .flag    (invalid_flag)
    );

    assign ovr_valid  = ovr_valid_q;
    assign ovr_result = ovr_result_q;
endmodule

// File: rtl/nan_result_sel_chk.sv
module nan_result_sel_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [1:0]            op_class,
    input logic                  dflt_mode,
    input logic                  flag_clr,
    input logic                  ovr_valid,
    input logic [EXP_W+FRAC_W:0] ovr_result,
    input logic                  invalid_flag
);
    localparam logic [EXP_W+FRAC_W:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // R1
    nan_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_valid |-> (&ovr_result[FRAC_W +: EXP_W]) && (|ovr_result[FRAC_W-1:0]));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !ovr_valid && (ovr_result == '0));

    // R3
    dflt_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'd0 && dflt_mode) |=> (!ovr_valid || ovr_result == DFLT_NAN));

    // R4
    arith_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 2'd0) |=> (!ovr_valid || ovr_result[FRAC_W-1]));

    // R6
    silent_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class != 2'd0 && !invalid_flag) |=> !invalid_flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !flag_clr) |=> invalid_flag);
endmodule

bind nan_result_sel nan_result_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_class     (op_class),
    .dflt_mode    (dflt_mode),
    .flag_clr     (flag_clr),
    .ovr_valid    (ovr_valid),
    .ovr_result   (ovr_result),
    .invalid_flag (invalid_flag)
);

// File: tb/test_nan_result_sel.sv
`timescale 1ns/1ps
module test_nan_result_sel;

    typedef struct packed {
        logic [1:0]  cls;
        logic        dm;
        logic [1:0]  sa;
        logic        two;
        logic [31:0] a;
        logic [31:0] b;
        logic        ev;
        logic [31:0] er;
        logic        ei;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] QA  = 32'h7FC1_2345;
    localparam logic [31:0] QB  = 32'hFFC0_0001;
    localparam logic [31:0] SA  = 32'h7F80_0055;
    localparam logic [31:0] SB  = 32'hFF80_0077;
    localparam logic [31:0] INF = 32'h7F80_0000;
    localparam logic [31:0] ONE = 32'h3F80_0000;
    localparam logic [31:0] DN  = 32'h7FC0_0000;
    localparam int NV = 19;

    // cls dm sa two a b | ev er ei | req
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 2'd0, 1'b1, ONE, ONE, 1'b0, 32'h0,        1'b0, 8'd1},  // R1 numbers
        '{2'd0, 1'b0, 2'd0, 1'b1, INF, ONE, 1'b0, 32'h0,        1'b0, 8'd1},  // R1 infinity
        '{2'd0, 1'b1, 2'd0, 1'b1, QA,  ONE, 1'b1, DN,           1'b0, 8'd3},  // R3 quiet in default mode
        '{2'd0, 1'b1, 2'd1, 1'b1, ONE, SB,  1'b1, DN,           1'b1, 8'd3},  // R3 R5 signalling in default mode
        '{2'd0, 1'b0, 2'd0, 1'b1, QA,  QB,  1'b1, QA,           1'b0, 8'd4},  // R4 quiet A over quiet B
        '{2'd0, 1'b0, 2'd0, 1'b1, ONE, QB,  1'b1, QB,           1'b0, 8'd4},  // R4 only B
        '{2'd0, 1'b0, 2'd0, 1'b1, QA,  SB,  1'b1, 32'hFFC0_0077, 1'b1, 8'd4}, // R4 signalling B over quiet A
        '{2'd0, 1'b0, 2'd0, 1'b1, SA,  SB,  1'b1, 32'h7FC0_0055, 1'b1, 8'd4}, // R4 signalling A first
        '{2'd0, 1'b0, 2'd2, 1'b1, QB,  ONE, 1'b1, QB,           1'b0, 8'd4},  // R4 sign action ignored
        '{2'd0, 1'b0, 2'd0, 1'b1, QA,  ONE, 1'b1, QA,           1'b0, 8'd5},  // R5 quiet sets no flag
        '{2'd0, 1'b0, 2'd0, 1'b0, ONE, SB,  1'b0, 32'h0,        1'b0, 8'd9},  // R9 B unused
        '{2'd1, 1'b0, 2'd2, 1'b0, SA,  ONE, 1'b1, 32'hFF80_0055, 1'b0, 8'd6}, // R6 negate
        '{2'd1, 1'b0, 2'd1, 1'b0, SB,  ONE, 1'b1, 32'h7F80_0077, 1'b0, 8'd6}, // R6 absolute
        '{2'd1, 1'b0, 2'd0, 1'b0, QB,  ONE, 1'b1, QB,           1'b0, 8'd6},  // R6 keep
        '{2'd1, 1'b1, 2'd2, 1'b0, QA,  ONE, 1'b1, 32'hFFC1_2345, 1'b0, 8'd6}, // R6 mode ignored
        '{2'd1, 1'b0, 2'd0, 1'b1, ONE, QA,  1'b0, 32'h0,        1'b0, 8'd9},  // R9 copy ignores B
        '{2'd2, 1'b1, 2'd2, 1'b0, SB,  ONE, 1'b1, SB,           1'b0, 8'd7},  // R7 bit exact
        '{2'd3, 1'b0, 2'd1, 1'b0, SA,  ONE, 1'b1, SA,           1'b0, 8'd7},  // R7 class 3
        '{2'd2, 1'b0, 2'd0, 1'b0, ONE, SA,  1'b0, 32'h0,        1'b0, 8'd7}   // R7 non-NaN
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic        dflt_mode = 1'b0;
    logic [1:0]  sign_act = 2'd0;
    logic        two_opnd = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        flag_clr = 1'b0;
    logic        ovr_valid;
    logic [31:0] ovr_result;
    logic        invalid_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nan_result_sel i_nan_result_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_class     (op_class),
        .dflt_mode    (dflt_mode),
        .sign_act     (sign_act),
        .two_opnd     (two_opnd),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .flag_clr     (flag_clr),
        .ovr_valid    (ovr_valid),
        .ovr_result   (ovr_result),
        .invalid_flag (invalid_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic v, input logic [1:0] c, input logic dm,
                         input logic [1:0] s, input logic t, input logic [31:0] a,
                         input logic [31:0] b, input logic clr);
        @(negedge clk);
        in_valid  = v;
        op_class  = c;
        dflt_mode = dm;
        sign_act  = s;
        two_opnd  = t;
        opnd_a    = a;
        opnd_b    = b;
        flag_clr  = clr;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        flag_clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10", "ovr_valid", {31'b0, ovr_valid}, 32'h0);
        check("R10", "ovr_result", ovr_result, 32'h0);
        check("R10", "invalid_flag", {31'b0, invalid_flag}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table: each vector clears the flag in the same cycle, so the
        // expected flag reflects only that vector's set condition (R8).
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            issue(1'b1, VECS[i].cls, VECS[i].dm, VECS[i].sa, VECS[i].two,
                  VECS[i].a, VECS[i].b, 1'b1);
            check(tag, "ovr_valid", {31'b0, ovr_valid}, {31'b0, VECS[i].ev});
            check(tag, "ovr_result", ovr_result, VECS[i].er);
            check(tag, "invalid_flag", {31'b0, invalid_flag}, {31'b0, VECS[i].ei});
        end

        // R8 flag holds over idle cycles after a set
        issue(1'b1, 2'd0, 1'b0, 2'd0, 1'b1, SA, ONE, 1'b0);
        check("R8", "flag set", {31'b0, invalid_flag}, 32'h1);
        issue(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, ONE, ONE, 1'b0);
        issue(1'b1, 2'd0, 1'b0, 2'd0, 1'b1, QA, ONE, 1'b0);
        check("R8", "flag held", {31'b0, invalid_flag}, 32'h1);
        // R8 clear pulse
        issue(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, ONE, ONE, 1'b1);
        check("R8", "flag cleared", {31'b0, invalid_flag}, 32'h0);

        // R2 an unissued signalling operation produces nothing
        issue(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, SA, SB, 1'b0);
        check("R2", "idle ovr_valid", {31'b0, ovr_valid}, 32'h0);
        check("R2", "idle ovr_result", ovr_result, 32'h0);
        check("R5", "idle no flag", {31'b0, invalid_flag}, 32'h0);

        // R2 result lasts one cycle only
        issue(1'b1, 2'd2, 1'b0, 2'd0, 1'b0, QA, ONE, 1'b0);
        check("R2", "one-cycle valid", {31'b0, ovr_valid}, 32'h1);
        @(posedge clk);
        #1;
        check("R2", "next cycle valid", {31'b0, ovr_valid}, 32'h0);

        // R10 asynchronous reset clears a set flag
        issue(1'b1, 2'd0, 1'b1, 2'd0, 1'b1, SA, ONE, 1'b0);
        check("R5", "flag set again", {31'b0, invalid_flag}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", "reset flag", {31'b0, invalid_flag}, 32'h0);
        check("R10", "reset valid", {31'b0, ovr_valid}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule